// File: doc/BRIEF.md
# Printer Carriage Control Tape Emulator

This block stands in for the punched carriage control loop of a line printer. It holds a form of 66 lines, each line carrying 12 channel punch bits, together with the line the form currently rests on. After reset the form holds a built-in default pattern. The host can overwrite any line with a one-line-per-cycle load write. A sequence of such writes replaces the whole tape image.

The printer adapter moves the form with two kinds of request. A space request moves it 1, 2 or 3 lines. A skip request names a channel, and the form then steps one line per cycle until it lands on a line punched in that channel. The form wraps from the last line to the first. A skip on a channel that has no punch anywhere stops after one full turn and raises an error. Two flags report whether the current line is punched in channel 9 or channel 12; the adapter uses them as form-overflow indicators.

The block reports not ready from reset until the host sends an enable pulse. No movement is accepted before that pulse.

Top module: `carriage_tape`

## Requirements
- R1: After reset, `not_ready` is 1, `busy` and `done` are 0, and `line_no` is 1.
- R2: The default form has channel 1 punched on line 1 only, channel 9 on line 65 only, and channel 12 on line 66 only. Channel c is bit c-1 of a row.
- R3: In the default form, every other channel c (2–8, 10, 11) is punched on each line whose number is a multiple of c.
- R4: `not_ready` stays 1 until an `enable_req` pulse, then stays 0 until reset. Requests made while `not_ready` is 1 are ignored.
- R5: A space request (`cmd_skip`=0) with `cmd_arg` from 1 to 3 advances `line_no` by exactly that count, wrapping 66→1. `done` pulses for one cycle, `cmd_arg` cycles after acceptance. Space counts of 0 or above 3 are ignored.
- R6: A skip request (`cmd_skip`=1, `cmd_arg`=channel 1–12) advances one line per cycle from the line after the current one, wrapping 66→1, and stops on the first line punched in that channel. If only the starting line is punched, it stops there after 66 steps with no error.
- R7: A skip on a channel punched on no line takes 66 steps, ends on the starting line, and asserts `skip_err` in the same cycle as `done`.
- R8: `ovf_hit` equals the channel 9 bit of the current line, and `eof_hit` equals the channel 12 bit.
- R9: A load write (`ld_we`) with `ld_line` from 1 to 66 replaces that line's row with `ld_row`. It is ignored for a line number of 0 or above 66, and while `busy` is 1.
- R10: Requests are ignored while `busy` is 1. A skip with channel 0 or above 12 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_req | input | 1 | Pulse that clears not ready |
| ld_we | input | 1 | Load write strobe for one line |
| ld_line | input | 7 | Line number (1–66) to write |
| ld_row | input | 12 | Punch bits for that line, bit c-1 = channel c |
| cmd_valid | input | 1 | Movement request strobe |
| cmd_skip | input | 1 | 1 = skip to channel, 0 = space |
| cmd_arg | input | 4 | Channel (skip) or line count (space) |
| not_ready | output | 1 | Device not ready |
| busy | output | 1 | Movement in progress |
| done | output | 1 | One-cycle pulse at the end of a movement |
| skip_err | output | 1 | Skip found no punch, valid with done |
| line_no | output | 7 | Current line, 1–66 |
| ovf_hit | output | 1 | Current line punched in channel 9 |
| eof_hit | output | 1 | Current line punched in channel 12 |

## Verification
The bench goes after wrap-around. It spaces off line 66 and skips across the 66→1 boundary. A design that is off by one there would land on line 67 or skip line 1. It skips on channel 1 while sitting on line 1, which must take a full 66-step turn and report no error. A design that tested the starting line would stop at once. It clears a channel from every line to provoke the error path, then checks that the form returns to its start. It also checks that loads to line 0, to line 67 and during motion leave the tape unchanged; a design that aliased those writes would make a later skip stop early. Finally it checks that requests with bad arguments, sent before enable or during motion, leave the form unmoved.

// File: rtl/ctape_pkg.sv
package ctape_pkg;

  localparam int unsigned FORM_LINES = 66;
  localparam int unsigned CHANNELS   = 12;
  localparam int unsigned MAX_SPACE  = 3;
  localparam int unsigned ROW_MAXW   = 32;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_SPACE = 2'd1,
    MV_SKIP  = 2'd2
  } move_e;

  // Factory punch row for a 1-based line number.
  function automatic logic [ROW_MAXW-1:0] default_row(int line, int chans, int lines);
    logic [ROW_MAXW-1:0] r;
    r = '0;
    for (int c = 1; c <= chans; c++) begin
      if (c == 1)       r[c-1] = (line == 1);
      else if (c == 9)  r[c-1] = (line == lines - 1);
      else if (c == 12) r[c-1] = (line == lines);
      else              r[c-1] = ((line % c) == 0);
    end
    return r;
  endfunction

endpackage

// File: rtl/ctape_mem.sv
module ctape_mem #(
  parameter int LINES = 66,
  parameter int CHANS = 12,
  parameter int LW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_line,
  input  logic [CHANS-1:0] wr_row,
  input  logic [LW-1:0]    rda_line,
  output logic [CHANS-1:0] rda_row,
  input  logic [LW-1:0]    rdb_line,
  output logic [CHANS-1:0] rdb_row
);

  logic [LINES-1:0][CHANS-1:0] rows;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [ctape_pkg::ROW_MAXW-1:0] INIT_W =
      ctape_pkg::default_row(g + 1, CHANS, LINES);
    localparam logic [CHANS-1:0] INIT = INIT_W[CHANS-1:0];
    logic             sel;
    logic [CHANS-1:0] row_q;
    logic [CHANS-1:0] row_d;

    assign sel = wr_en && (wr_line == LW'(g + 1));

    always_comb begin
      row_d = row_q;
      if (sel) row_d = wr_row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row_q <= INIT;
      else if (sel) row_q <= row_d;
    end

    assign rows[g] = row_q;
  end

  always_comb begin
    rda_row = '0;
    rdb_row = '0;
    for (int i = 0; i < LINES; i++) begin
      if (rda_line == LW'(i + 1)) rda_row = rows[i];
      if (rdb_line == LW'(i + 1)) rdb_row = rows[i];
    end
  end

endmodule

// File: rtl/ctape_move.sv
module ctape_move #(
  parameter int LINES = 66,
  parameter int CHANS = 12,
  parameter int LW    = 7,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_req,
  input  logic             cmd_valid,
  input  logic             cmd_skip,
  input  logic [CW-1:0]    cmd_arg,
  input  logic [CHANS-1:0] next_row,
  output logic [LW-1:0]    line_q,
  output logic [LW-1:0]    next_line,
  output logic             rdy_q,
  output logic             busy_q,
  output logic             done_q,
  output logic             err_q
);
  import ctape_pkg::*;

  move_e            mode_q, mode_d;
  logic [CHANS-1:0] mask_q, mask_d;
  logic [LW-1:0]    cnt_q, cnt_d;
  logic [LW-1:0]    line_d;
  logic             rdy_d, done_d, err_d;
  logic             arg_ok, accept, hit, last, stop;

  assign next_line = (line_q == LW'(LINES)) ? LW'(1) : line_q + LW'(1);
  assign hit       = |(next_row & mask_q);
  assign last      = (cnt_q == LW'(1));
  assign arg_ok    = cmd_skip ? (cmd_arg >= CW'(1) && cmd_arg <= CW'(CHANS))
                              : (cmd_arg >= CW'(1) && cmd_arg <= CW'(MAX_SPACE));
  assign accept    = rdy_q && (mode_q == MV_IDLE) && cmd_valid && arg_ok;
  assign stop      = (mode_q == MV_SKIP) ? (hit || last) : last;
  assign busy_q    = (mode_q != MV_IDLE);

  always_comb begin
    rdy_d  = rdy_q | enable_req;
    mode_d = mode_q;
    mask_d = mask_q;
    cnt_d  = cnt_q;
    line_d = line_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (accept) begin
      mode_d = cmd_skip ? MV_SKIP : MV_SPACE;
      mask_d = CHANS'(1) << (cmd_arg - CW'(1));
      cnt_d  = cmd_skip ? LW'(LINES) : LW'(cmd_arg);
    end else if (busy_q) begin
      line_d = next_line;
      cnt_d  = cnt_q - LW'(1);
      if (stop) begin
        mode_d = MV_IDLE;
        done_d = 1'b1;
        err_d  = (mode_q == MV_SKIP) && !hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      mode_q <= MV_IDLE;
      mask_q <= '0;
      cnt_q  <= '0;
      line_q <= LW'(1);
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      mode_q <= mode_d;
      if (accept) mask_q <= mask_d;
      if (accept || busy_q) begin
        cnt_q  <= cnt_d;
        line_q <= line_d;
      end
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

endmodule

// File: rtl/carriage_tape.sv
module carriage_tape #(
  parameter int LINES  = ctape_pkg::FORM_LINES,
  parameter int CHANS  = ctape_pkg::CHANNELS,
  parameter int OVF_CH = 9,
  parameter int EOF_CH = 12,
  localparam int LW    = $clog2(LINES + 1),
  localparam int CW    = $clog2(CHANS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_req,
  input  logic             ld_we,
  input  logic [LW-1:0]    ld_line,
  input  logic [CHANS-1:0] ld_row,
  input  logic             cmd_valid,
  input  logic             cmd_skip,
  input  logic [CW-1:0]    cmd_arg,
  output logic             not_ready,
  output logic             busy,
  output logic             done,
  output logic             skip_err,
  output logic [LW-1:0]    line_no,
  output logic             ovf_hit,
  output logic             eof_hit
);

  logic [LW-1:0]    cur_line, nxt_line;
  logic [CHANS-1:0] cur_row, nxt_row;
  logic             rdy, busy_i;

  ctape_mem #(.LINES(LINES), .CHANS(CHANS), .LW(LW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ld_we && !busy_i),
    .wr_line  (ld_line),
    .wr_row   (ld_row),
    .rda_line (cur_line),
    .rda_row  (cur_row),
    .rdb_line (nxt_line),
    .rdb_row  (nxt_row)
  );

  ctape_move #(.LINES(LINES), .CHANS(CHANS), .LW(LW), .CW(CW)) u_move (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_req (enable_req),
    .cmd_valid  (cmd_valid),
    .cmd_skip   (cmd_skip),
    .cmd_arg    (cmd_arg),
    .next_row   (nxt_row),
    .line_q     (cur_line),
    .next_line  (nxt_line),
    .rdy_q      (rdy),
    .busy_q     (busy_i),
    .done_q     (done),
    .err_q      (skip_err)
  );

  assign not_ready = !rdy;
  assign busy      = busy_i;
  assign line_no   = cur_line;
  assign ovf_hit   = cur_row[OVF_CH-1];
  assign eof_hit   = cur_row[EOF_CH-1];

endmodule

// File: rtl/ctape_chk.sv
module ctape_chk #(
  parameter int LINES = 66,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          not_ready,
  input logic          busy,
  input logic          done,
  input logic          skip_err,
  input logic [LW-1:0] line_no
);

  p_line_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_no >= LW'(1)) && (line_no <= LW'(LINES)));

  // R6 / R5: one line per busy cycle, with wrap
  p_step_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (line_no == (($past(line_no) == LW'(LINES)) ? LW'(1) : $past(line_no) + LW'(1))));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(line_no));

  p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (not_ready && !busy) |=> !busy);

  p_ready_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !not_ready |=> !not_ready);

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_err |-> done);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind carriage_tape ctape_chk #(.LINES(LINES), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .not_ready (not_ready),
  .busy      (busy),
  .done      (done),
  .skip_err  (skip_err),
  .line_no   (line_no)
);

// File: tb/sim_carriage_tape.sv
`timescale 1ns/1ps
module sim_carriage_tape;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable_req, ld_we, cmd_valid, cmd_skip;
  logic [6:0]  ld_line;
  logic [11:0] ld_row;
  logic [3:0]  cmd_arg;
  logic        not_ready, busy, done, skip_err, ovf_hit, eof_hit;
  logic [6:0]  line_no;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  carriage_tape u0 (
    .clk(clk), .rst_n(rst_n), .enable_req(enable_req),
    .ld_we(ld_we), .ld_line(ld_line), .ld_row(ld_row),
    .cmd_valid(cmd_valid), .cmd_skip(cmd_skip), .cmd_arg(cmd_arg),
    .not_ready(not_ready), .busy(busy), .done(done), .skip_err(skip_err),
    .line_no(line_no), .ovf_hit(ovf_hit), .eof_hit(eof_hit)
  );

  // Stimulus table walked from line 1 after enable, default form.
  localparam int NV = 11;
  localparam int V_SKIP [NV] = '{0, 1, 1, 0, 1,  0, 1,  1,  1,  1,  1};
  localparam int V_ARG  [NV] = '{2, 3, 5, 3, 12, 1, 9,  7,  1,  1,  11};
  localparam int V_LINE [NV] = '{3, 6, 10,13,66, 1, 65, 7,  1,  1,  11};
  localparam int V_CYC  [NV] = '{2, 3, 4, 3, 53, 1, 64, 8,  60, 66, 10};

  function automatic logic [11:0] form_row(int ln);
    logic [11:0] r = '0;
    for (int c = 1; c <= 12; c++) begin
      if (c == 1)       r[c-1] = (ln == 1);
      else if (c == 9)  r[c-1] = (ln == 65);
      else if (c == 12) r[c-1] = (ln == 66);
      else              r[c-1] = (ln % c == 0);
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic sk, input int arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_skip = sk; cmd_arg = 4'(arg);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc, output logic err);
    cyc = 0; err = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cyc++;
      if (done) begin err = skip_err; break; end
    end
  endtask

  task automatic load(input int ln, input logic [11:0] row);
    @(negedge clk);
    ld_we = 1'b1; ld_line = 7'(ln); ld_row = row;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int   cyc;
    logic err;
    rst_n = 1'b0; enable_req = 1'b0; ld_we = 1'b0; cmd_valid = 1'b0;
    cmd_skip = 1'b0; cmd_arg = '0; ld_line = '0; ld_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(not_ready === 1'b1, "R1 not_ready", not_ready, 1);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(line_no === 7'd1, "R1 line", line_no, 1);
    chk(ovf_hit === 1'b0 && eof_hit === 1'b0, "R8 flags at line 1", {ovf_hit, eof_hit}, 0);

    // R4 request before enable is ignored
    issue(1'b0, 1);
    repeat (4) @(negedge clk);
    chk(line_no === 7'd1, "R4 ignored before enable line", line_no, 1);
    chk(busy === 1'b0, "R4 ignored before enable busy", busy, 0);

    @(negedge clk); enable_req = 1'b1;
    @(negedge clk); enable_req = 1'b0;
    chk(not_ready === 1'b0, "R4 enable clears not_ready", not_ready, 0);

    // R5 / R10 bad arguments ignored
    issue(1'b0, 0);  chk(busy === 1'b0, "R5 space 0 ignored", busy, 0);
    issue(1'b0, 4);  chk(busy === 1'b0, "R5 space 4 ignored", busy, 0);
    issue(1'b1, 0);  chk(busy === 1'b0, "R10 skip ch0 ignored", busy, 0);
    issue(1'b1, 13); chk(busy === 1'b0, "R10 skip ch13 ignored", busy, 0);
    @(negedge clk);
    chk(line_no === 7'd1, "R10 line unchanged after bad args", line_no, 1);

    // Table: R2 R3 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      issue(V_SKIP[v] != 0, V_ARG[v]);
      wait_done(cyc, err);
      chk(line_no === 7'(V_LINE[v]), $sformatf("R6/R5 vec%0d line", v), line_no, V_LINE[v]);
      chk(cyc == V_CYC[v], $sformatf("R6/R5 vec%0d cycles", v), cyc, V_CYC[v]);
      chk(err === 1'b0, $sformatf("R6 vec%0d no error", v), err, 0);
      chk(ovf_hit === (V_LINE[v] == 65), $sformatf("R8 vec%0d ch9 flag", v), ovf_hit, V_LINE[v] == 65);
      chk(eof_hit === (V_LINE[v] == 66), $sformatf("R8 vec%0d ch12 flag", v), eof_hit, V_LINE[v] == 66);
    end

    // R9 load: strip channel 10 from every line, then R7 error skip
    for (int ln = 10; ln <= 60; ln += 10) load(ln, form_row(ln) & ~12'h200);
    issue(1'b1, 10);
    wait_done(cyc, err);
    chk(err === 1'b1, "R7 skip error flagged", err, 1);
    chk(cyc == 66, "R7 full revolution", cyc, 66);
    chk(line_no === 7'd11, "R7 back to start line", line_no, 11);

    load(33, form_row(33) | 12'h200);
    issue(1'b1, 10);
    wait_done(cyc, err);
    chk(line_no === 7'd33, "R9 loaded punch found", line_no, 33);
    chk(cyc == 22, "R9 loaded punch cycles", cyc, 22);

    // R9 out-of-range loads ignored; R6 only-start-line punched
    load(0, 12'hFFF);
    load(67, 12'hFFF);
    issue(1'b1, 10);
    wait_done(cyc, err);
    chk(line_no === 7'd33 && cyc == 66, "R9 bad line loads ignored (line)", line_no, 33);
    chk(err === 1'b0, "R6 start-line only punch no error", err, 0);

    // R9 load during motion ignored, R10 request during motion ignored
    issue(1'b1, 10);
    ld_we = 1'b1; ld_line = 7'd40; ld_row = 12'hFFF;
    cmd_valid = 1'b1; cmd_skip = 1'b0; cmd_arg = 4'd1;
    @(negedge clk);
    ld_we = 1'b0; cmd_valid = 1'b0;
    wait_done(cyc, err);
    chk(line_no === 7'd33, "R9 busy load ignored", line_no, 33);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && line_no === 7'd33, "R10 busy request ignored", line_no, 33);
    issue(1'b1, 10);
    wait_done(cyc, err);
    chk(cyc == 66 && line_no === 7'd33, "R9 row 40 unchanged", cyc, 66);

    // R3 a channel 4 skip from 33 lands on 36
    issue(1'b1, 4);
    wait_done(cyc, err);
    chk(line_no === 7'd36 && cyc == 3, "R3 channel 4 multiple", line_no, 36);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule